// File: doc/BRIEF.md
# March-Test Memory Self-Test Controller

This controller runs a chosen march algorithm over a bit-oriented memory of `N_CELLS` single-bit cells. A march algorithm is an ordered list of elements. Each element sweeps the whole address range, either upward or downward, and applies a short fixed sequence of reads and writes to every cell. It finishes all of those operations on one cell before it moves to the next address. Each read carries the value that a good memory must return. When a read returns anything else, a fault has been found.

A start pulse latches the algorithm code and begins the run. The controller issues one memory operation per clock. It samples each read result `READ_LAT` cycles after the read is issued, which matches a memory with registered output. The first mismatch stores the failing address and element index. The run always continues to the end. When the run is complete, `done` rises and `pass` reports the result. Both stay valid until the next start.

Top module: `march_bist`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail`, `mem_we` and `mem_re` are all 0.
- R2: `algo_sel` selects the algorithm as follows.
  - 0: {up(w0); up(r0,w1); up(r1)}
  - 1: {up(w0); up(r0,w1); down(r1,w0)}
  - 2: {up(w0); up(r0,w1); down(r1,w0,r0)}
  - 3: {up(w0); up(r0,w1); down(r1,w0); up(r0)}
  - 4: {up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0)}
  - 5, 6 and 7 run the same algorithm as code 1.
  - Elements are numbered from 0 in the listed order.
- R3: The controller issues exactly one operation per cycle, with no gaps, from the cycle after the start edge onward.
  - An upward element visits addresses 0 to N_CELLS-1.
  - A downward element visits addresses N_CELLS-1 down to 0.
  - All operations of an element on one cell are consecutive.
  - A read drives `mem_re`=1 and `mem_we`=0.
  - A write drives `mem_we`=1 with `mem_wdata` set to the written value.
  - `mem_we` and `mem_re` are never both high.
- R4: With T = (operations per cell) × N_CELLS, `done` first reads 1 in cycle T+READ_LAT after the start edge. `busy` is 1 from the start edge until then, and `done` and `busy` are never both 1.
- R5: Read data is sampled `READ_LAT` cycles after the read is issued and compared with the expected value of that read.
- R6: The first mismatch sets `fail` and stores `fail_addr` and `fail_elem`. Later mismatches in the same run change none of them, and the run still completes.
- R7: While `done` is 1, `pass` is 1 exactly when no mismatch occurred in the run.
- R8: A start pulse while `busy` is 1 is ignored. `algo_sel` is sampled only on an accepted start.
- R9: An accepted start after `done` clears `fail` and runs the test afresh.
- R10: While `busy` is 0, `mem_we` and `mem_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test when idle or done |
| algo_sel | input | 3 | Algorithm code, sampled at start |
| mem_addr | output | ADDR_W | Cell address of the current operation |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 1 | Write data |
| mem_rdata | input | 1 | Read data, valid READ_LAT cycles after mem_re |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test complete, result valid |
| pass | output | 1 | No mismatch seen (valid with done) |
| fail | output | 1 | A mismatch has been seen |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |

## Verification
A corrupted element, address or operation counter shows up at the memory strobes in the very next cycle, as a wrong address, a wrong strobe or a wrong write value. The cycle-by-cycle trace comparison therefore catches it at once. A wrong compare pipeline or a wrong first-failure latch only becomes visible when `done` rises. It then appears as a wrong `pass`, `fail_addr` or `fail_elem`. Stuck cells are injected at every address, both singly and in pairs, so that a wrong failure address or a wrong sweep direction changes the reported location.

// File: rtl/march_pkg.sv
package march_pkg;

   localparam int ELEM_W = 3;
   localparam int ALG_W  = 3;

   typedef struct packed {
      logic wr;
      logic val;
   } mop_t;

   typedef struct packed {
      logic       down;
      logic [1:0] len;
      mop_t [2:0] ops;
   } melem_t;

   typedef enum logic [ALG_W-1:0] {
      ALG_MATS     = 3'd0,
      ALG_MATS_P   = 3'd1,
      ALG_MATS_PP  = 3'd2,
      ALG_MARCH_X  = 3'd3,
      ALG_MARCH_CM = 3'd4
   } alg_e;

   localparam mop_t OP_R0 = 2'b00;
   localparam mop_t OP_R1 = 2'b01;
   localparam mop_t OP_W0 = 2'b10;
   localparam mop_t OP_W1 = 2'b11;

   function automatic melem_t mk_elem(input logic down, input logic [1:0] len,
                                      input mop_t a, input mop_t b, input mop_t c);
      melem_t r;
      r.down   = down;
      r.len    = len;
      r.ops[0] = a;
      r.ops[1] = b;
      r.ops[2] = c;
      return r;
   endfunction

   function automatic alg_e alg_decode(input logic [ALG_W-1:0] code);
      return (code > 3'd4) ? ALG_MATS_P : alg_e'(code);
   endfunction

   function automatic logic [ELEM_W-1:0] alg_num_elems(input alg_e a);
      case (a)
         ALG_MARCH_X:  return 3'd4;
         ALG_MARCH_CM: return 3'd6;
         default:      return 3'd3;
      endcase
   endfunction

   function automatic melem_t alg_elem(input alg_e a, input logic [ELEM_W-1:0] e);
      melem_t r;
      r = mk_elem(1'b0, 2'd1, OP_W0, OP_W0, OP_W0);
      if (e == 3'd1)
         r = mk_elem(1'b0, 2'd2, OP_R0, OP_W1, OP_W1);
      case (a)
         ALG_MATS: begin
            if (e == 3'd2) r = mk_elem(1'b0, 2'd1, OP_R1, OP_R1, OP_R1);
         end
         ALG_MATS_P: begin
            if (e == 3'd2) r = mk_elem(1'b1, 2'd2, OP_R1, OP_W0, OP_W0);
         end
         ALG_MATS_PP: begin
            if (e == 3'd2) r = mk_elem(1'b1, 2'd3, OP_R1, OP_W0, OP_R0);
         end
         ALG_MARCH_X: begin
            if (e == 3'd2) r = mk_elem(1'b1, 2'd2, OP_R1, OP_W0, OP_W0);
            if (e == 3'd3) r = mk_elem(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
         end
         ALG_MARCH_CM: begin
            case (e)
               3'd2:    r = mk_elem(1'b0, 2'd2, OP_R1, OP_W0, OP_W0);
               3'd3:    r = mk_elem(1'b1, 2'd2, OP_R0, OP_W1, OP_W1);
               3'd4:    r = mk_elem(1'b1, 2'd2, OP_R1, OP_W0, OP_W0);
               3'd5:    r = mk_elem(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
               default: ;
            endcase
         end
         default: ;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/march_table.sv
module march_table
   import march_pkg::*;
(
   input  alg_e              alg,
   input  logic [ELEM_W-1:0] idx,
   output melem_t            elem,
   output logic [ELEM_W-1:0] n_elems
);

   assign elem    = alg_elem(alg, idx);
   assign n_elems = alg_num_elems(alg);

endmodule

// File: rtl/march_seq.sv
module march_seq
   import march_pkg::*;
#(
   parameter int N_CELLS  = 1024,
   parameter int ADDR_W   = $clog2(N_CELLS),
   parameter int READ_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ALG_W-1:0]  alg_code,
   output logic              busy,
   output logic              done,
   output logic              clr,
   output logic              op_valid,
   output mop_t              op,
   output logic [ADDR_W-1:0] op_addr,
   output logic [ELEM_W-1:0] op_elem
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_CELLS - 1);
   localparam int                CNT_W     = (READ_LAT > 1) ? $clog2(READ_LAT) : 1;

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_e;

   state_e            state_q;
   alg_e              alg_q;
   logic [ELEM_W-1:0] elem_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        opi_q;
   logic [CNT_W-1:0]  drain_q;

   melem_t            cur;
   logic [ELEM_W-1:0] n_elems;
   logic              last_op, last_addr, last_elem;
   logic              first_down, next_down;

   march_table u_table (
      .alg     (alg_q),
      .idx     (elem_q),
      .elem    (cur),
      .n_elems (n_elems)
   );

   always_comb begin
      melem_t f, n;
      f          = alg_elem(alg_decode(alg_code), '0);
      n          = alg_elem(alg_q, elem_q + 3'd1);
      first_down = f.down;
      next_down  = n.down;
   end

   assign last_op   = (opi_q == cur.len - 2'd1);
   assign last_addr = cur.down ? (addr_q == '0) : (addr_q == LAST_ADDR);
   assign last_elem = (elem_q == n_elems - 3'd1);
   assign clr       = start && ((state_q == S_IDLE) || (state_q == S_DONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         alg_q   <= ALG_MATS;
         elem_q  <= '0;
         addr_q  <= '0;
         opi_q   <= '0;
         drain_q <= '0;
      end else begin
         case (state_q)
            S_IDLE, S_DONE: begin
               if (clr) begin
                  alg_q   <= alg_decode(alg_code);
                  elem_q  <= '0;
                  opi_q   <= '0;
                  addr_q  <= first_down ? LAST_ADDR : '0;
                  state_q <= S_RUN;
               end
            end
            S_RUN: begin
               if (!last_op) begin
                  opi_q <= opi_q + 2'd1;
               end else begin
                  opi_q <= '0;
                  if (!last_addr) begin
                     addr_q <= cur.down ? (addr_q - 1'b1) : (addr_q + 1'b1);
                  end else if (last_elem) begin
                     state_q <= S_DRAIN;
                     drain_q <= CNT_W'(READ_LAT - 1);
                  end else begin
                     elem_q <= elem_q + 3'd1;
                     addr_q <= next_down ? LAST_ADDR : '0;
                  end
               end
            end
            S_DRAIN: begin
               if (drain_q == '0) state_q <= S_DONE;
               else               drain_q <= drain_q - 1'b1;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == S_RUN) || (state_q == S_DRAIN);
   assign done     = (state_q == S_DONE);
   assign op_valid = (state_q == S_RUN);
   assign op       = cur.ops[opi_q];
   assign op_addr  = addr_q;
   assign op_elem  = elem_q;

endmodule

// File: rtl/march_cmp.sv
module march_cmp
   import march_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int READ_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rd_issue,
   input  logic              exp_val,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ELEM_W-1:0] rd_elem,
   input  logic              mem_rdata,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [ELEM_W-1:0] fail_elem
);

   localparam int PW = 2 + ADDR_W + ELEM_W;

   logic [PW-1:0]     stage_in;
   logic [PW-1:0]     tail;
   logic              t_vld, t_exp, mism;
   logic [ADDR_W-1:0] t_addr;
   logic [ELEM_W-1:0] t_elem;

   assign stage_in = {rd_issue, exp_val, rd_addr, rd_elem};

   generate
      if (READ_LAT == 1) begin : g_lat1
         logic [PW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= stage_in;
         end
         assign tail = q;
      end else begin : g_latn
         logic [PW-1:0] q [1:READ_LAT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 1; s <= READ_LAT; s++) q[s] <= '0;
            end else begin
               q[1] <= stage_in;
               for (int s = 2; s <= READ_LAT; s++) q[s] <= q[s-1];
            end
         end
         assign tail = q[READ_LAT];
      end
   endgenerate

   assign {t_vld, t_exp, t_addr, t_elem} = tail;
   assign mism = t_vld && (mem_rdata != t_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
      end else if (clr) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
      end else if (mism && !fail) begin
         fail      <= 1'b1;
         fail_addr <= t_addr;
         fail_elem <= t_elem;
      end
   end

endmodule

// File: rtl/march_bist.sv
module march_bist
   import march_pkg::*;
#(
   parameter int N_CELLS  = 1024,
   parameter int ADDR_W   = $clog2(N_CELLS),
   parameter int READ_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        algo_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic              mem_wdata,
   input  logic              mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem
);

   generate
      if (N_CELLS < 2) begin : g_bad_cells
         initial $fatal(1, "march_bist: N_CELLS must be at least 2");
      end
      if ((1 << ADDR_W) < N_CELLS) begin : g_bad_addr
         initial $fatal(1, "march_bist: ADDR_W too narrow for N_CELLS");
      end
      if (READ_LAT < 1 || READ_LAT > 8) begin : g_bad_lat
         initial $fatal(1, "march_bist: READ_LAT must be 1..8");
      end
   endgenerate

   logic              clr, op_valid;
   mop_t              op;
   logic [ADDR_W-1:0] op_addr;
   logic [ELEM_W-1:0] op_elem;

   march_seq #(
      .N_CELLS  (N_CELLS),
      .ADDR_W   (ADDR_W),
      .READ_LAT (READ_LAT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .alg_code (algo_sel),
      .busy     (busy),
      .done     (done),
      .clr      (clr),
      .op_valid (op_valid),
      .op       (op),
      .op_addr  (op_addr),
      .op_elem  (op_elem)
   );

   assign mem_addr  = op_addr;
   assign mem_we    = op_valid && op.wr;
   assign mem_re    = op_valid && !op.wr;
   assign mem_wdata = op_valid && op.val;

   march_cmp #(
      .ADDR_W   (ADDR_W),
      .READ_LAT (READ_LAT)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .rd_issue  (mem_re),
      .exp_val   (op.val),
      .rd_addr   (op_addr),
      .rd_elem   (op_elem),
      .mem_rdata (mem_rdata),
      .fail      (fail),
      .fail_addr (fail_addr),
      .fail_elem (fail_elem)
   );

   assign pass = done && !fail;

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
   parameter int N_CELLS = 1024,
   parameter int ADDR_W  = $clog2(N_CELLS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] fail_addr
);

   AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R3
   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || mem_re) |-> (32'(mem_addr) < N_CELLS)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_we && !mem_re)); // R10
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy)); // R4
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy)); // R4
   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (busy && fail) |=> fail); // R6
   AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && fail) |=> $stable(fail_addr)); // R6

endmodule

bind march_bist march_bist_chk #(
   .N_CELLS (N_CELLS),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .fail      (fail),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_addr  (mem_addr),
   .fail_addr (fail_addr)
);

// File: tb/march_bist_tb.sv
module march_bist_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 12;
   localparam int AW = 4;
   localparam int RL = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    algo_sel = 3'd0;
   logic [AW-1:0] mem_addr;
   logic          mem_we, mem_re, mem_wdata;
   logic          mem_rdata;
   logic          busy, done, pass, fail;
   logic [AW-1:0] fail_addr;
   logic [2:0]    fail_elem;

   int checks = 0;
   int failures = 0;

   // Fault injection: cells stuck at a value on read.
   bit f1_en = 0, f2_en = 0;
   int fc1 = 0, fc2 = 0;
   bit fv = 0;
   logic bm [0:15];

   always #(CLK_PERIOD/2) clk = ~clk;

   march_bist #(.N_CELLS(N), .ADDR_W(AW), .READ_LAT(RL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
      .fail_elem(fail_elem)
   );

   // Memory model with registered read output.
   always @(posedge clk) begin
      if (mem_we) bm[mem_addr] <= mem_wdata;
      if (mem_re) begin
         if ((f1_en && int'(mem_addr) == fc1) || (f2_en && int'(mem_addr) == fc2))
            mem_rdata <= fv;
         else
            mem_rdata <= bm[mem_addr];
      end
   end

   // Element encoding: [8]=down, [7:6]=len, then three ops {wr,val}.
   function automatic logic [8:0] b_elem(input int a, input int e);
      case (a)
         0: case (e) 0: return 9'b0_01_10_00_00; 1: return 9'b0_10_00_11_00;
                     default: return 9'b0_01_01_00_00; endcase
         1: case (e) 0: return 9'b0_01_10_00_00; 1: return 9'b0_10_00_11_00;
                     default: return 9'b1_10_01_10_00; endcase
         2: case (e) 0: return 9'b0_01_10_00_00; 1: return 9'b0_10_00_11_00;
                     default: return 9'b1_11_01_10_00; endcase
         3: case (e) 0: return 9'b0_01_10_00_00; 1: return 9'b0_10_00_11_00;
                     2: return 9'b1_10_01_10_00; default: return 9'b0_01_00_00_00; endcase
         default: case (e) 0: return 9'b0_01_10_00_00; 1: return 9'b0_10_00_11_00;
                     2: return 9'b0_10_01_10_00; 3: return 9'b1_10_00_11_00;
                     4: return 9'b1_10_01_10_00; default: return 9'b0_01_00_00_00; endcase
      endcase
   endfunction

   function automatic int b_nelem(input int a);
      return (a == 3) ? 4 : (a == 4) ? 6 : 3;
   endfunction

   function automatic int b_total(input int a);
      int t = 0;
      for (int e = 0; e < b_nelem(a); e++) t += int'(b_elem(a, e)[7:6]) * N;
      return t;
   endfunction

   task automatic exp_op(input int a, input int k, output int addr, output bit wr, output bit val);
      int rem = k;
      addr = 0; wr = 0; val = 0;
      for (int e = 0; e < b_nelem(a); e++) begin
         logic [8:0] el = b_elem(a, e);
         int len = int'(el[7:6]);
         if (rem < len * N) begin
            int pos = rem / len;
            int j = rem % len;
            logic [1:0] o = el[5-2*j -: 2];
            addr = el[8] ? (N - 1 - pos) : pos;
            wr = o[1];
            val = o[0];
            return;
         end
         rem -= len * N;
      end
   endtask

   task automatic check(input bit ok, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   task automatic run(input logic [2:0] sel, input bit mid_start, input bit exp_fail,
                      input int exp_addr, input int exp_elem, input string tag);
      int a = (sel > 3'd4) ? 1 : int'(sel);
      int t = b_total(a);
      int bad = 0;
      int done_at = -1;
      int first_bad = -1;
      @(negedge clk);
      algo_sel = sel; start = 1'b1;
      @(negedge clk);
      start = 1'b0; algo_sel = sel + 3'd1;   // R8: changes after start must not matter
      for (int cyc = 0; cyc < t + 40; cyc++) begin
         if (done) begin done_at = cyc; break; end
         if (mid_start && cyc == 5) begin start = 1'b1; algo_sel = sel + 3'd2; end
         if (mid_start && cyc == 6) start = 1'b0;
         if (cyc < t) begin
            int ea; bit ew, ev;
            exp_op(a, cyc, ea, ew, ev);
            if (!busy || mem_we != ew || mem_re != !ew || int'(mem_addr) != ea ||
                (ew && mem_wdata != ev) || (mem_we && mem_re)) begin
               bad++;
               if (first_bad < 0) first_bad = cyc;
            end
         end else if (mem_we || mem_re || !busy) begin
            bad++;
         end
         @(negedge clk);
      end
      check(bad == 0, {tag, " R2 R3 op trace mismatches (first cycle in actual)"}, first_bad, -1);
      check(done_at == t + RL, {tag, " R4 done cycle"}, done_at, t + RL);
      check(!busy && !mem_we && !mem_re, {tag, " R10 quiet after done"}, {busy, mem_we, mem_re}, 0);
      check(fail == exp_fail && pass == !exp_fail, {tag, " R5 R7 verdict fail"}, fail, exp_fail);
      if (exp_fail) begin
         check(int'(fail_addr) == exp_addr, {tag, " R6 first fail address"}, fail_addr, exp_addr);
         check(int'(fail_elem) == exp_elem, {tag, " R6 first fail element"}, fail_elem, exp_elem);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) bm[i] = i[0];
      mem_rdata = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy && !done && !pass && !fail && !mem_we && !mem_re, "R1 reset state",
            {busy, done, pass, fail, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !mem_we && !mem_re, "R1 R10 idle after reset",
            {busy, done, mem_we, mem_re}, 0);

      for (int a = 0; a < 5; a++) begin
         f1_en = 0; f2_en = 0;
         run(3'(a), 1'b1, 1'b0, 0, 0, "clean R9");
         // Single stuck-at cells: SA1 first caught by element 1, SA0 by element 2.
         for (int c = 0; c < N; c++) begin
            for (int v = 0; v < 2; v++) begin
               f1_en = 1; fc1 = c; fv = v[0];
               run(3'(a), (c == 3), 1'b1, c, v ? 1 : 2, "single SA");
            end
         end
         // Two SA0 cells: the sweep direction of element 2 picks the reported one.
         for (int i = 0; i < N / 2; i++) begin
            f1_en = 1; f2_en = 1; fc1 = i; fc2 = N - 1 - i; fv = 1'b0;
            run(3'(a), 1'b0, 1'b1, b_elem(a, 2)[8] ? (N - 1 - i) : i, 2, "pair SA0 R6");
         end
         f1_en = 0; f2_en = 0;
         run(3'(a), 1'b0, 1'b0, 0, 0, "clean after fail R9");
      end
      // Unsupported codes behave like code 1 (R2).
      for (int s = 5; s < 8; s++) begin
         f1_en = 1; f2_en = 0; fc1 = s; fv = 1'b0;
         run(3'(s), 1'b0, 1'b1, s, 2, "spare code R2");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule